// File: doc/BRIEF.md
# Prioritized Nested Interrupt Collector

The block gathers level-sensitive interrupt lines from up to 127 sources and presents them to a processor as one request line. Every source owns a small control register holding an enable bit and a two-bit priority. Among the sources that are raised, enabled and allowed to run, the collector picks a winner and raises `irq`. It also presents the winner's number in a status word, which holds its value until software takes the request.

Software services a request in two steps. A write of any value to the take register drops `irq` and marks the winner's priority level as in service. A later write to the level-retire register clears that level. While a level is in service, only sources at a strictly higher level can raise `irq`, so a more urgent source can preempt a handler that is already running. When nothing may be reported, the status word reads the reserved code 0x7f. Source number 127 therefore does not exist: its number is the reserved code.

The sequencer has two states. In `ST_IDLE` no request is outstanding. The transition *grant* goes to `ST_RAISED` at the first clock edge at which the arbiter reports an eligible source, and it latches that source's number and level. In `ST_RAISED` the request line is high. The transition *take* returns to `ST_IDLE` on a write to the take register.

Top module: `nest_irq_collector`

## Requirements
- R1: After reset every enable bit is 0, every priority is 0, no level is in service, `irq` is low and the status word (address 0x800) reads 0x7f.
- R2: Source n has a register block at byte address n*0x10. Offset +0 is the plain register, +4 the set alias and +8 the clear alias. A one written through the set or clear alias sets or clears only that bit. All other bits keep their values.
- R3: Each source register holds the enable in bit 0 and the priority in bits 9:8. It reads back through any of its three aliases. Undefined bits read 0.
- R4: When idle, `irq` rises one clock after a source is seen raised, enabled and eligible.
- R5: Among eligible sources, the one with the highest priority wins (3 is the highest). A tie goes to the lowest source number. The winner's number appears in bits 6:0 of the status word.
- R6: While `irq` is high, the reported number stays stable until the take register (0x804) is written, even if a more urgent source arrives in the meantime.
- R7: A write of any value to 0x804 while `irq` is high drops `irq` on the next clock. It also puts the reported source's level in service.
- R8: A source may raise `irq` only if its level is strictly higher than every level in service. A higher level preempts a lower level that is in service.
- R9: Writing a mask to 0x808 clears the in-service levels whose bits are set (bit k is level k). Pending sources at or below a cleared level become eligible again.
- R10: A source whose enable bit is 0 is never reported. Setting the bit again lets the source compete.
- R11: While `irq` is low, the status word reads 0x7f. A write to 0x804 while `irq` is low puts no level in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| src_lvl | input | NSRC | level-sensitive interrupt lines, one per source |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from `bus_addr` |
| irq | output | 1 | request line to the processor |

## Verification
Sources are raised one at a time, in groups of equal priority and in groups of mixed priority. This separates the priority comparison from the tie-break on the lowest source number. Nested scenarios take a low level and then raise a higher one, which must preempt it. A raised source at the level already in service must stay silent until that level is retired. A more urgent source that arrives while `irq` is already high shows that the reported number is held. Disabled sources, a take written while idle, and writes through the set and clear aliases that carry extra bits show that these inputs leave the outputs and the register contents unchanged.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RAISED = 1'b1
    } nic_state_e;

    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } nic_access_e;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_PRI_LSB = 8;
endpackage

// File: rtl/nic_src_regs.sv
module nic_src_regs
    import nic_pkg::*;
#(
    parameter int NSRC  = 127,
    parameter int PRI_W = 2,
    parameter int IDX_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  nic_access_e           wr_kind,
    input  logic [31:0]           wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [NSRC-1:0]       en_vec,
    output logic [NSRC*PRI_W-1:0] pri_flat,
    output logic [31:0]           rd_word
);
    logic             d_en;
    logic [PRI_W-1:0] d_pri;

    assign d_en  = wr_data[CFG_EN_BIT];
    assign d_pri = wr_data[CFG_PRI_LSB +: PRI_W];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic             en_q;
        logic [PRI_W-1:0] pri_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q  <= 1'b0;
                pri_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                unique case (wr_kind)
                    ACC_PLAIN: begin en_q <= d_en;          pri_q <= d_pri;          end
                    ACC_SET:   begin en_q <= en_q | d_en;   pri_q <= pri_q | d_pri;  end
                    ACC_CLR:   begin en_q <= en_q & ~d_en;  pri_q <= pri_q & ~d_pri; end
                    default:   ;
                endcase
            end
        end

        assign en_vec[i]               = en_q;
        assign pri_flat[i*PRI_W +: PRI_W] = pri_q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_word[CFG_EN_BIT]              = en_vec[i];
                rd_word[CFG_PRI_LSB +: PRI_W]    = pri_flat[i*PRI_W +: PRI_W];
            end
        end
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int NSRC  = 127,
    parameter int PRI_W = 2,
    parameter int VEC_W = 7
) (
    input  logic [NSRC-1:0]       pend,
    input  logic [NSRC-1:0]       en_vec,
    input  logic [NSRC*PRI_W-1:0] pri_flat,
    input  logic [PRI_W:0]        ceil,
    output logic                  found,
    output logic [VEC_W-1:0]      win_idx,
    output logic [PRI_W-1:0]      win_pri
);
    always_comb begin
        logic [PRI_W-1:0] p;
        found   = 1'b0;
        win_idx = '0;
        win_pri = '0;
        // Descending scan with >= leaves the lowest index on a tie (R5).
        for (int i = NSRC - 1; i >= 0; i--) begin
            p = pri_flat[i*PRI_W +: PRI_W];
            if (pend[i] && en_vec[i] && ({1'b0, p} >= ceil) &&
                (!found || p >= win_pri)) begin
                found   = 1'b1;
                win_idx = VEC_W'(i);
                win_pri = p;
            end
        end
    end
endmodule

// File: rtl/nic_seq.sv
module nic_seq
    import nic_pkg::*;
#(
    parameter int PRI_W = 2,
    parameter int VEC_W = 7,
    parameter int NLVL  = 1 << PRI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found,
    input  logic [VEC_W-1:0] win_idx,
    input  logic [PRI_W-1:0] win_pri,
    input  logic             take,
    input  logic             ack,
    input  logic [NLVL-1:0]  ack_mask,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [PRI_W:0]   ceil
);
    localparam logic [VEC_W-1:0] SPUR = {VEC_W{1'b1}};

    nic_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [PRI_W-1:0] pri_q;
    logic [NLVL-1:0]  inserv_q, inserv_d;
    logic             grant, taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        taken   = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (found) begin state_d = ST_RAISED; grant = 1'b1; end
            ST_RAISED: if (take)  begin state_d = ST_IDLE;   taken = 1'b1; end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        inserv_d = inserv_q;
        if (taken) inserv_d = inserv_d | (NLVL'(1) << pri_q);
        if (ack)   inserv_d = inserv_d & ~ack_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q    <= SPUR;
            pri_q    <= '0;
            inserv_q <= '0;
        end else begin
            inserv_q <= inserv_d;
            if (grant) begin
                vec_q <= win_idx;
                pri_q <= win_pri;
            end else if (taken) begin
                vec_q <= SPUR;
            end
        end
    end

    always_comb begin
        ceil = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (inserv_q[l]) ceil = (PRI_W+1)'(l + 1);
        end
    end

    assign irq = (state_q == ST_RAISED);
    assign vec = vec_q;

    a_r4_grant_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && found) |=> irq);
    a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !take) |=> (irq && $stable(vec)));
    a_r7_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && take) |=> !irq);
    a_r8_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((inserv_q >> pri_q) == '0));
    a_r9_level_retired: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((inserv_q & $past(ack_mask)) == '0));
    a_r11_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == SPUR));
endmodule

// File: rtl/nest_irq_collector.sv
module nest_irq_collector
    import nic_pkg::*;
#(
    parameter int NSRC   = 127,
    parameter int PRI_W  = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int VEC_W = 7;
    localparam int NLVL  = 1 << PRI_W;
    localparam int IDX_W = ADDR_W - 5;

    logic                  glb_sel, idx_ok, src_hit;
    logic [IDX_W-1:0]      idx;
    nic_access_e           kind;
    logic [NSRC-1:0]       en_vec;
    logic [NSRC*PRI_W-1:0] pri_flat;
    logic [31:0]           rd_word;
    logic                  found;
    logic [VEC_W-1:0]      win_idx, vec;
    logic [PRI_W-1:0]      win_pri;
    logic [PRI_W:0]        ceil;
    logic                  glb_row0, take, ack;
    logic                  unused_bits;

    assign glb_sel  = bus_addr[ADDR_W-1];
    assign idx      = bus_addr[ADDR_W-2:4];
    assign kind     = nic_access_e'(bus_addr[3:2]);
    assign idx_ok   = ({1'b0, idx} < (IDX_W+1)'(NSRC));
    assign src_hit  = !glb_sel && idx_ok && (kind != ACC_NONE);
    assign glb_row0 = glb_sel && (idx == '0);
    assign take     = bus_wr && glb_row0 && (kind == ACC_SET);
    assign ack      = bus_wr && glb_row0 && (kind == ACC_CLR);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:10], bus_wdata[7:1]};

    nic_src_regs #(.NSRC(NSRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && src_hit), .wr_idx(idx), .wr_kind(kind),
        .wr_data(bus_wdata), .rd_idx(idx),
        .en_vec(en_vec), .pri_flat(pri_flat), .rd_word(rd_word)
    );

    nic_arbiter #(.NSRC(NSRC), .PRI_W(PRI_W), .VEC_W(VEC_W)) u_arb (
        .pend(src_lvl), .en_vec(en_vec), .pri_flat(pri_flat), .ceil(ceil),
        .found(found), .win_idx(win_idx), .win_pri(win_pri)
    );

    nic_seq #(.PRI_W(PRI_W), .VEC_W(VEC_W), .NLVL(NLVL)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .found(found), .win_idx(win_idx), .win_pri(win_pri),
        .take(take), .ack(ack), .ack_mask(bus_wdata[NLVL-1:0]),
        .irq(irq), .vec(vec), .ceil(ceil)
    );

    always_comb begin
        bus_rdata = '0;
        if (src_hit)                          bus_rdata = rd_word;
        else if (glb_row0 && kind == ACC_PLAIN) bus_rdata = {{(32-VEC_W){1'b0}}, vec};
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

// File: tb/nest_irq_collector_bench.sv
module nest_irq_collector_bench;
    localparam int NS = 127;
    localparam logic [11:0] A_STAT = 12'h800, A_TAKE = 12'h804, A_ACK = 12'h808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = A_STAT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nest_irq_collector u_nest_irq_collector (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference model
    bit m_en[NS];
    int m_pr[NS];
    int m_inserv = 0;
    bit m_irq = 0;
    int m_vec = 127, m_lvl = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int top_level();
        int t = -1;
        for (int l = 0; l < 4; l++) if (m_inserv[l]) t = l;
        return t;
    endfunction

    always @(posedge clk) begin
        int w_i, w_p, idx, k;
        bit f;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_pr[i] = 0; end
            m_inserv = 0; m_irq = 0; m_vec = 127; m_lvl = 0;
        end else begin
            f = 0; w_i = 0; w_p = 0;
            for (int p = 3; p > top_level() && !f; p--)
                for (int i = 0; i < NS && !f; i++)
                    if (src_lvl[i] && m_en[i] && m_pr[i] == p) begin f = 1; w_i = i; w_p = p; end
            if (!m_irq) begin
                if (f) begin m_irq = 1; m_vec = w_i; m_lvl = w_p; end
            end else if (bus_wr && bus_addr == A_TAKE) begin
                m_irq = 0; m_inserv = m_inserv | (1 << m_lvl); m_vec = 127;
            end
            if (bus_wr && bus_addr == A_ACK) m_inserv = m_inserv & ~int'(bus_wdata[3:0]);
            idx = int'(bus_addr[10:4]); k = int'(bus_addr[3:2]);
            if (bus_wr && !bus_addr[11] && idx < NS) begin
                if (k == 0) begin m_en[idx] = bus_wdata[0]; m_pr[idx] = int'(bus_wdata[9:8]); end
                if (k == 1) begin m_en[idx] |= bus_wdata[0]; m_pr[idx] |= int'(bus_wdata[9:8]); end
                if (k == 2) begin m_en[idx] &= ~bus_wdata[0]; m_pr[idx] &= ~int'(bus_wdata[9:8]); end
            end
        end
        #1;
        if (rst_n && !done) begin
            check("R4 irq vs model", int'(irq), int'(m_irq));
            if (!bus_wr && bus_addr == A_STAT) check("R6 status vs model", int'(bus_rdata), m_vec);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_addr = A_STAT; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output int d);
        @(negedge clk); bus_addr = a; #1 d = int'(bus_rdata);
        @(negedge clk); bus_addr = A_STAT;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int s, input int pri);
        wr(12'(s * 16), 32'(1 | (pri << 8)));
    endtask

    task automatic lvl(input int s, input bit v);
        @(negedge clk); src_lvl[s] = v;
    endtask

    initial begin
        int d;
        waitc(3); rst_n = 1; waitc(1);
        // R1
        check("R1 irq", int'(irq), 0);
        rd(A_STAT, d); check("R1 status", d, 32'h7f);
        rd(12'h050, d); check("R1 src5 reg", d, 0);
        // R2, R3
        wr(12'h034, 32'h1);   rd(12'h030, d); check("R2 set en", d, 32'h001);
        wr(12'h034, 32'h200); rd(12'h030, d); check("R2 set pri", d, 32'h201);
        wr(12'h038, 32'h1);   rd(12'h030, d); check("R2 clr en", d, 32'h200);
        wr(12'h030, 32'hffff_ffff); rd(12'h038, d); check("R3 readback alias", d, 32'h301);
        wr(12'h030, 32'h0);   rd(12'h034, d); check("R3 plain clear", d, 0);
        // R10: disabled source stays silent
        wr(12'h070, 32'h300); lvl(7, 1); waitc(4);
        check("R10 disabled silent", int'(irq), 0);
        wr(12'h074, 32'h1); waitc(2);
        check("R10 re-enabled irq", int'(irq), 1);
        rd(A_STAT, d); check("R10 vector", d, 7);
        // R7, R8, R9
        wr(A_TAKE, 32'h0); check("R7 take drops irq", int'(irq), 0);
        waitc(3); check("R8 same level blocked", int'(irq), 0);
        wr(A_ACK, 32'h8); waitc(1); check("R9 retire reasserts", int'(irq), 1);
        wr(A_TAKE, 32'h5a5a); lvl(7, 0); wr(A_ACK, 32'h8); waitc(2);
        check("R11 idle irq", int'(irq), 0);
        rd(A_STAT, d); check("R11 idle status", d, 32'h7f);
        // R5 priority and tie-break
        cfg(40, 2); cfg(12, 2); cfg(90, 1);
        @(negedge clk); src_lvl[40] = 1; src_lvl[12] = 1; src_lvl[90] = 1;
        waitc(2); rd(A_STAT, d); check("R5 tie lowest index", d, 12);
        wr(A_TAKE, 0);
        cfg(100, 3); lvl(100, 1); waitc(2);
        rd(A_STAT, d); check("R8 preempt nested", d, 100);
        wr(A_TAKE, 0); lvl(100, 0); wr(A_ACK, 32'h8); waitc(3);
        check("R8 level2 still blocks", int'(irq), 0);
        wr(A_ACK, 32'h4); waitc(2); rd(A_STAT, d); check("R9 retire re-elects", d, 12);
        wr(A_TAKE, 0); lvl(12, 0); wr(A_ACK, 32'h4); waitc(2);
        rd(A_STAT, d); check("R5 next in tie", d, 40);
        wr(A_TAKE, 0); lvl(40, 0); wr(A_ACK, 32'h4); waitc(2);
        rd(A_STAT, d); check("R5 lower priority", d, 90);
        // R6: vector held while raised
        cfg(5, 3); lvl(5, 1); waitc(3);
        rd(A_STAT, d); check("R6 held vector", d, 90);
        wr(A_TAKE, 0); waitc(2);
        rd(A_STAT, d); check("R8 preempt level1", d, 5);
        wr(A_TAKE, 0); lvl(5, 0); lvl(90, 0); wr(A_ACK, 32'hf); waitc(2);
        // R11: take while idle must not put a level in service
        wr(A_TAKE, 32'hffff_ffff); waitc(1);
        check("R11 spurious take", int'(irq), 0);
        cfg(60, 0); lvl(60, 1); waitc(2);
        check("R11 level0 still eligible", int'(irq), 1);
        rd(A_STAT, d); check("R11 level0 vector", d, 60);
        wr(A_TAKE, 0); lvl(60, 0); wr(A_ACK, 32'h1); waitc(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1; checks++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule